// File: doc/BRIEF.md
# Multiprocessor 9-bit UART port

This block is a full-duplex asynchronous serial port. Software reaches it through a small register bus with two locations. Location 0 is a byte-wide control and status register. Location 1 is the data register: a write there loads the transmitter, and a read returns the last accepted received byte. The port runs from an external baud tick that pulses once per sixteenth of a bit time. It drives one serial output line, samples one serial input line, and raises one interrupt line. Baud generation, FIFOs and a synchronous shift mode are not part of the block.

Frames carry one start bit, the data bits LSB first, an optional ninth bit and one stop bit. In the 9-bit modes the ninth transmitted bit comes from a control bit that software sets, so it can carry parity or an address/data marker. The ninth received bit is stored in a status bit. A multiprocessor filter can be enabled. With the filter on, a 9-bit frame whose ninth bit is 0 is dropped silently, so only address frames (ninth bit 1) complete a reception. The two event flags ignore written ones. Software clears one flag by writing a mask that has a single zero in that flag's position. A hardware set in the same cycle as a clear-write wins over the clear.

The transmitter state machine has five states: `TX_IDLE`, `TX_START`, `TX_DATA`, `TX_NINTH` and `TX_STOP`. A data write arms it, and the next tick moves it from `TX_IDLE` to `TX_START`. After 16 ticks in a state it moves on: `TX_START` to `TX_DATA`, then `TX_DATA` to `TX_NINTH` (9-bit modes) or to `TX_STOP` (8-bit mode), `TX_NINTH` to `TX_STOP`, and `TX_STOP` back to `TX_IDLE`, which also sets the transmit-done flag. The receiver state machine has five states: `RX_IDLE`, `RX_START`, `RX_DATA`, `RX_NINTH` and `RX_STOP`. It moves from `RX_IDLE` to `RX_START` when it sees a low line on a tick. On the eighth tick `RX_START` goes to `RX_DATA` if the line is still low, and back to `RX_IDLE` if it is not. Each 16 ticks `RX_DATA` takes one bit, and after the last data bit it goes to `RX_NINTH` or to `RX_STOP`. `RX_NINTH` goes to `RX_STOP`, and `RX_STOP` goes to `RX_IDLE`, where the frame is accepted or dropped. If reception is disabled, any receiver state goes to `RX_IDLE`.

Top module: `uart9_port`

## Requirements
- R1: After reset the control register reads 0x00, the serial output is high (idle) and the interrupt is low.
- R2: Control bits [7:6] select the mode: 01 is an 8-bit frame, 10 and 11 are both 9-bit frames, and 00 disables the port. In mode 00 a data write sends nothing, the transmit-done flag stays clear and no frame is received.
- R3: A write to location 1 while the transmitter is idle sends, each bit lasting 16 baud ticks, a low start bit, the 8 data bits LSB first, in 9-bit modes control bit 0 (transmit ninth bit), then a high stop bit. A data write while a frame is in progress is ignored.
- R4: Control bit 2 (transmit done) is set when the stop bit of a sent frame ends.
- R5: A received frame that is accepted writes its 8 data bits to the receive data register (read at location 1) and sets control bit 3 (receive done). Reception requires control bit 5 (receive enable) set.
- R6: On an accepted frame control bit 1 (received ninth bit) takes the received ninth bit in 9-bit modes. In 8-bit mode with the filter off it takes the received stop bit.
- R7: With control bit 4 (multiprocessor filter) set in a 9-bit mode, a frame whose ninth bit is 0 sets no flag, raises no interrupt and leaves the data register unchanged. A frame whose ninth bit is 1 is accepted.
- R8: While receive enable is clear, incoming frames set no flag and leave the data register unchanged.
- R9: A start pulse shorter than half a bit is rejected without a reception, and a following valid frame is still received.
- R10: Writing 1 to a done flag leaves it unchanged and writing 0 clears it. A hardware set in the same cycle as a clearing write leaves the flag set.
- R11: The interrupt output is high exactly when at least one done flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 1 | Register select: 0 control/status, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_o | output | 1 | Interrupt request |

## Verification
A receiver stuck in a wrong state, or a bit counter one off, shows up at the ports as a shifted byte in the data register or a wrong ninth-bit status within one frame time (about 11 bit times). A transmitter out of step shows as a misplaced edge on the serial line at the next bit boundary, or as a done flag early or late by a whole bit. A filter or flag-priority fault shows at the first frame that ends: a flag or interrupt appears when it should not, or it is missing. The race case is driven by holding a clearing write across the whole frame end, so a clear that wins over the set is never seen as a high flag.

// File: rtl/uart9_pkg.sv
package uart9_pkg;

    // Mode field values (control bits [7:6])
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_BYTE   = 2'b01,
        MODE_NINE_A = 2'b10,
        MODE_NINE_B = 2'b11
    } mode_e;

    // Control/status bit positions
    localparam int unsigned CF_MODE_HI = 7;
    localparam int unsigned CF_MODE_LO = 6;
    localparam int unsigned CF_RX_EN   = 5;
    localparam int unsigned CF_MP_EN   = 4;
    localparam int unsigned CF_RX_DONE = 3;
    localparam int unsigned CF_TX_DONE = 2;
    localparam int unsigned CF_RX_B9   = 1;
    localparam int unsigned CF_TX_B9   = 0;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_NINTH,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_NINTH,
        RX_STOP
    } rx_state_e;

    function automatic logic mode_is_nine(input mode_e m);
        return (m == MODE_NINE_A) || (m == MODE_NINE_B);
    endfunction

    function automatic logic mode_is_on(input mode_e m);
        return m != MODE_OFF;
    endfunction

endpackage

// File: rtl/uart9_tx.sv
module uart9_tx
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              start,
    input  logic              nine,
    input  logic              b9_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              tx_o,
    output logic              busy,
    output logic              done_pulse
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    tx_state_e         state_q, state_d;
    logic              armed_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shr_q;
    logic              b9_q;
    logic              nine_q;
    logic              bit_end;

    assign bit_end = baud_tick && (cnt_q == CNT_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (armed_q && baud_tick) state_d = TX_START;
            TX_START: if (bit_end) state_d = TX_DATA;
            TX_DATA:  if (bit_end && (idx_q == IDX_LAST))
                          state_d = nine_q ? TX_NINTH : TX_STOP;
            TX_NINTH: if (bit_end) state_d = TX_STOP;
            TX_STOP:  if (bit_end) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: arming, bit timing, shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            idx_q   <= '0;
            shr_q   <= '0;
            b9_q    <= 1'b0;
            nine_q  <= 1'b0;
        end else begin
            if (start && !busy) begin
                armed_q <= 1'b1;
                shr_q   <= data_in;
                b9_q    <= b9_in;
                nine_q  <= nine;
            end else if (state_q == TX_IDLE && state_d == TX_START) begin
                armed_q <= 1'b0;
            end

            if (state_q != state_d)
                cnt_q <= '0;
            else if (baud_tick && state_q != TX_IDLE)
                cnt_q <= cnt_q + 1'b1;

            if (state_q != TX_DATA && state_d == TX_DATA)
                idx_q <= '0;
            else if (state_q == TX_DATA && bit_end) begin
                idx_q <= idx_q + 1'b1;
                shr_q <= shr_q >> 1;
            end
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            TX_START: tx_o = 1'b0;
            TX_DATA:  tx_o = shr_q[0];
            TX_NINTH: tx_o = b9_q;
            default:  tx_o = 1'b1;
        endcase
        busy       = armed_q || (state_q != TX_IDLE);
        done_pulse = (state_q == TX_STOP) && bit_end;
    end

    AST_TX_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(tx_o)); // R3

    AST_TX_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (state_q == TX_IDLE) && tx_o); // R4

endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
    import uart9_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              rx_i,
    input  logic              en,
    input  logic              nine,
    input  logic              mp_en,
    output logic              done_pulse,
    output logic [DATA_W-1:0] data_o,
    output logic              b9_we,
    output logic              b9_val
);

    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

    rx_state_e              state_q, state_d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;
    logic [CNT_W-1:0]       cnt_q;
    logic [IDX_W-1:0]       idx_q;
    logic [DATA_W-1:0]      shr_q;
    logic                   b9_q;
    logic                   nine_q;
    logic                   bit_end;
    logic                   finish;
    logic                   accept;

    // Input synchronizer, idles high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
    end
    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign bit_end = baud_tick && (cnt_q == CNT_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  if (baud_tick && !rx_s) state_d = RX_START;
                RX_START: if (baud_tick && (cnt_q == CNT_MID))
                              state_d = rx_s ? RX_IDLE : RX_DATA;
                RX_DATA:  if (bit_end && (idx_q == IDX_LAST))
                              state_d = nine_q ? RX_NINTH : RX_STOP;
                RX_NINTH: if (bit_end) state_d = RX_STOP;
                RX_STOP:  if (bit_end) state_d = RX_IDLE;
                default:  state_d = RX_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: bit timing and capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            shr_q  <= '0;
            b9_q   <= 1'b0;
            nine_q <= 1'b0;
        end else begin
            if (state_q != state_d)
                cnt_q <= '0;
            else if (baud_tick && state_q != RX_IDLE)
                cnt_q <= cnt_q + 1'b1;

            if (state_q == RX_IDLE && state_d == RX_START)
                nine_q <= nine;

            if (state_q != RX_DATA && state_d == RX_DATA)
                idx_q <= '0;
            else if (state_q == RX_DATA && bit_end) begin
                idx_q <= idx_q + 1'b1;
                shr_q <= {rx_s, shr_q[DATA_W-1:1]};
            end

            if (state_q == RX_NINTH && bit_end)
                b9_q <= rx_s;
        end
    end

    // Outputs: frame completion and acceptance
    always_comb begin
        finish     = en && (state_q == RX_STOP) && bit_end;
        accept     = !(nine_q && mp_en && !b9_q);
        done_pulse = finish && accept;
        data_o     = shr_q;
        b9_we      = done_pulse && (nine_q || !mp_en);
        b9_val     = nine_q ? b9_q : rx_s;
    end

    AST_RX_OFF_GOES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == RX_IDLE)); // R8

    AST_RX_DONE_LEAVES_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> (state_q == RX_IDLE)); // R5

endmodule

// File: rtl/uart9_regs.sv
module uart9_regs
    import uart9_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_busy,
    input  logic              tx_set,
    input  logic              rx_set,
    input  logic              rx_b9_we,
    input  logic              rx_b9_val,
    input  logic [DATA_W-1:0] rx_byte,
    output mode_e             mode,
    output logic              rx_en,
    output logic              mp_en,
    output logic              tx_b9,
    output logic              tx_start,
    output logic [DATA_W-1:0] tx_byte,
    output logic              irq_o
);

    mode_e             mode_q;
    logic              rx_en_q, mp_en_q, tx_b9_q, rx_b9_q;
    logic              tx_done_q, rx_done_q;
    logic [DATA_W-1:0] rx_data_q;
    logic              ctrl_wr;
    logic              tx_clr, rx_clr;

    assign ctrl_wr = bus_wr && !bus_addr;
    assign tx_clr  = ctrl_wr && !bus_wdata[CF_TX_DONE];
    assign rx_clr  = ctrl_wr && !bus_wdata[CF_RX_DONE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_OFF;
            rx_en_q   <= 1'b0;
            mp_en_q   <= 1'b0;
            tx_b9_q   <= 1'b0;
            rx_b9_q   <= 1'b0;
            tx_done_q <= 1'b0;
            rx_done_q <= 1'b0;
            rx_data_q <= '0;
        end else begin
            if (ctrl_wr) begin
                mode_q  <= mode_e'(bus_wdata[CF_MODE_HI:CF_MODE_LO]);
                rx_en_q <= bus_wdata[CF_RX_EN];
                mp_en_q <= bus_wdata[CF_MP_EN];
                tx_b9_q <= bus_wdata[CF_TX_B9];
            end
            if (rx_b9_we)     rx_b9_q <= rx_b9_val;
            else if (ctrl_wr) rx_b9_q <= bus_wdata[CF_RX_B9];
            // Hardware set has priority over a clearing write
            tx_done_q <= tx_set || (tx_done_q && !tx_clr);
            rx_done_q <= rx_set || (rx_done_q && !rx_clr);
            if (rx_set) rx_data_q <= rx_byte;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr) begin
            bus_rdata = rx_data_q;
        end else begin
            bus_rdata[CF_MODE_HI:CF_MODE_LO] = mode_q;
            bus_rdata[CF_RX_EN]   = rx_en_q;
            bus_rdata[CF_MP_EN]   = mp_en_q;
            bus_rdata[CF_RX_DONE] = rx_done_q;
            bus_rdata[CF_TX_DONE] = tx_done_q;
            bus_rdata[CF_RX_B9]   = rx_b9_q;
            bus_rdata[CF_TX_B9]   = tx_b9_q;
        end
        mode     = mode_q;
        rx_en    = rx_en_q;
        mp_en    = mp_en_q;
        tx_b9    = tx_b9_q;
        tx_start = bus_wr && bus_addr && mode_is_on(mode_q) && !tx_busy;
        tx_byte  = bus_wdata;
        irq_o    = tx_done_q || rx_done_q;
    end

    AST_RX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_set |=> rx_done_q); // R10

    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_set |=> tx_done_q); // R4

    AST_FLAG_KEEPS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[CF_RX_DONE] && rx_done_q) |=> rx_done_q); // R10

    AST_MP_ONLY_ADDRESS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_set && mode_is_nine(mode_q) && mp_en_q) |=> rx_b9_q); // R7

    AST_NO_RX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_q |-> !rx_set); // R8

    AST_NO_TX_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF && !tx_busy) |=> !tx_busy); // R2

endmodule

// File: rtl/uart9_port.sv
module uart9_port
    import uart9_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              baud_tick,
    input  logic              rx_i,
    output logic              tx_o,
    output logic              irq_o
);

    mode_e             mode;
    logic              rx_en, mp_en, tx_b9;
    logic              tx_start, tx_busy, tx_set;
    logic [DATA_W-1:0] tx_byte;
    logic              rx_set, rx_b9_we, rx_b9_val;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_active;

    assign rx_active = rx_en && mode_is_on(mode);

    uart9_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_busy   (tx_busy),
        .tx_set    (tx_set),
        .rx_set    (rx_set),
        .rx_b9_we  (rx_b9_we),
        .rx_b9_val (rx_b9_val),
        .rx_byte   (rx_byte),
        .mode      (mode),
        .rx_en     (rx_en),
        .mp_en     (mp_en),
        .tx_b9     (tx_b9),
        .tx_start  (tx_start),
        .tx_byte   (tx_byte),
        .irq_o     (irq_o)
    );

    uart9_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .start      (tx_start),
        .nine       (mode_is_nine(mode)),
        .b9_in      (tx_b9),
        .data_in    (tx_byte),
        .tx_o       (tx_o),
        .busy       (tx_busy),
        .done_pulse (tx_set)
    );

    uart9_rx #(.DATA_W(DATA_W), .OVS(OVS), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rx_i       (rx_i),
        .en         (rx_active),
        .nine       (mode_is_nine(mode)),
        .mp_en      (mp_en),
        .done_pulse (rx_set),
        .data_o     (rx_byte),
        .b9_we      (rx_b9_we),
        .b9_val     (rx_b9_val)
    );

endmodule

// File: tb/sim_uart9_port.sv
module sim_uart9_port;

    localparam logic [7:0] MODE8  = 8'h40;
    localparam logic [7:0] MODE9  = 8'h80;
    localparam logic [7:0] MODE9B = 8'hC0;
    localparam logic [7:0] RXEN   = 8'h20;
    localparam logic [7:0] MPEN   = 8'h10;
    localparam logic [7:0] RXD    = 8'h08;
    localparam logic [7:0] TXD    = 8'h04;
    localparam logic [7:0] RB9    = 8'h02;
    localparam logic [7:0] TB9    = 8'h01;
    localparam int BIT_CLK = 64; // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b0;
    logic       rx_line = 1'b1;
    logic       tx_line;
    logic       irq;
    int         n_checks = 0;
    int         n_fail = 0;
    int unsigned tick_div = 0;

    always #4 clk = ~clk;

    uart9_port u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .baud_tick (baud_tick),
        .rx_i      (rx_line),
        .tx_o      (tx_line),
        .irq_o     (irq)
    );

    initial begin
        forever begin
            @(negedge clk);
            tick_div  = (tick_div + 1) % 4;
            baud_tick = (tick_div == 0);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic drive_frame(input logic [7:0] d, input bit nine, input bit b9);
        @(negedge clk);
        rx_line = 1'b0;
        idle(BIT_CLK);
        for (int i = 0; i < 8; i++) begin
            rx_line = d[i];
            idle(BIT_CLK);
        end
        if (nine) begin
            rx_line = b9;
            idle(BIT_CLK);
        end
        rx_line = 1'b1;
        idle(BIT_CLK);
    endtask

    task automatic grab_tx(input bit nine, output logic [7:0] d, output logic b9,
                           output logic st, output logic sp, output bit seen);
        int t = 0;
        seen = 1'b0;
        d = 8'h00; b9 = 1'b0; st = 1'b1; sp = 1'b0;
        @(negedge clk);
        while (tx_line !== 1'b0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t < 2000) begin
            seen = 1'b1;
            idle(BIT_CLK / 2);
            st = tx_line;
            for (int i = 0; i < 8; i++) begin
                idle(BIT_CLK);
                d[i] = tx_line;
            end
            if (nine) begin
                idle(BIT_CLK);
                b9 = tx_line;
            end
            idle(BIT_CLK);
            sp = tx_line;
        end
    endtask

    task automatic watch_tx_quiet(input int n, output bit quiet);
        quiet = 1'b1;
        repeat (n) begin
            @(negedge clk);
            if (tx_line !== 1'b1) quiet = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [7:0] r;
        rd(1'b0, r);
        check(r == 8'h00, "R1 control after reset", r, 0);
        check(tx_line == 1'b1, "R1 tx idle high", tx_line, 1);
        check(irq == 1'b0, "R1 irq low", irq, 0);
    endtask

    task automatic t_tx_byte();
        logic [7:0] d, r;
        logic b9, st, sp;
        bit seen, quiet;
        wr(1'b0, MODE8);
        wr(1'b1, 8'hA5);
        idle(8);
        wr(1'b1, 8'h3C);            // busy: must be ignored
        grab_tx(1'b0, d, b9, st, sp, seen);
        check(seen, "R3 frame started", seen, 1);
        check(st == 1'b0, "R3 start bit", st, 0);
        check(d == 8'hA5, "R3 data LSB first", d, 8'hA5);
        check(sp == 1'b1, "R3 stop bit", sp, 1);
        idle(40);
        rd(1'b0, r);
        check(r[2] == 1'b1, "R4 tx done set", r[2], 1);
        check(irq == 1'b1, "R11 irq on tx done", irq, 1);
        watch_tx_quiet(300, quiet);
        check(quiet, "R3 write while busy ignored", quiet, 1);
        wr(1'b0, MODE8 | RXD);      // zero at tx done clears it
        rd(1'b0, r);
        check(r == MODE8, "R10 zero clears tx done", r, MODE8);
        check(irq == 1'b0, "R11 irq low with no flags", irq, 0);
        wr(1'b0, MODE8 | TXD);      // one on a clear flag
        rd(1'b0, r);
        check(r[2] == 1'b0, "R10 one leaves flag", r[2], 0);
    endtask

    task automatic t_tx_nine();
        logic [7:0] d, r;
        logic b9, st, sp;
        bit seen;
        wr(1'b0, MODE9 | TB9);
        wr(1'b1, 8'h3C);
        grab_tx(1'b1, d, b9, st, sp, seen);
        check(seen && d == 8'h3C, "R3 nine-bit data", d, 8'h3C);
        check(b9 == 1'b1, "R3 ninth bit one", b9, 1);
        check(sp == 1'b1, "R3 nine-bit stop", sp, 1);
        idle(40);
        rd(1'b0, r);
        check(r[2] == 1'b1, "R4 tx done after nine-bit", r[2], 1);
        wr(1'b0, MODE9B);
        wr(1'b1, 8'hC3);
        grab_tx(1'b1, d, b9, st, sp, seen);
        check(seen && d == 8'hC3, "R2 mode 11 data", d, 8'hC3);
        check(b9 == 1'b0 && sp == 1'b1, "R2 mode 11 is nine-bit", {b9, sp}, 1);
        idle(40);
        wr(1'b0, MODE8);
    endtask

    task automatic t_rx_byte();
        logic [7:0] r;
        wr(1'b0, MODE8 | RXEN);
        drive_frame(8'h5A, 1'b0, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b1, "R5 rx done set", r[3], 1);
        check(r[1] == 1'b1, "R6 stop bit captured", r[1], 1);
        check(irq == 1'b1, "R11 irq on rx done", irq, 1);
        rd(1'b1, r);
        check(r == 8'h5A, "R5 rx data", r, 8'h5A);
        wr(1'b0, MODE8 | RXEN);
    endtask

    task automatic t_rx_nine();
        logic [7:0] r;
        wr(1'b0, MODE9B | RXEN | RB9);
        drive_frame(8'h33, 1'b1, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b1, "R5 nine-bit rx done", r[3], 1);
        check(r[1] == 1'b0, "R6 ninth bit zero captured", r[1], 0);
        rd(1'b1, r);
        check(r == 8'h33, "R5 nine-bit rx data", r, 8'h33);
        wr(1'b0, MODE9B | RXEN);
    endtask

    task automatic t_mp_filter();
        logic [7:0] r;
        wr(1'b0, MODE9 | RXEN | MPEN);
        drive_frame(8'h44, 1'b1, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b0, "R7 data frame no flag", r[3], 0);
        check(irq == 1'b0, "R7 data frame no irq", irq, 0);
        rd(1'b1, r);
        check(r == 8'h33, "R7 data register kept", r, 8'h33);
        drive_frame(8'h12, 1'b1, 1'b1);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b1, "R7 address frame accepted", r[3], 1);
        check(r[1] == 1'b1, "R6 ninth bit one captured", r[1], 1);
        rd(1'b1, r);
        check(r == 8'h12, "R7 address byte", r, 8'h12);
        wr(1'b0, MODE8);
    endtask

    task automatic t_rx_off();
        logic [7:0] r;
        bit quiet;
        drive_frame(8'h77, 1'b0, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b0, "R8 no flag when disabled", r[3], 0);
        rd(1'b1, r);
        check(r == 8'h12, "R8 data kept when disabled", r, 8'h12);
        wr(1'b0, RXEN);             // mode 00
        drive_frame(8'h66, 1'b0, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b0, "R2 mode 00 no reception", r[3], 0);
        rd(1'b1, r);
        check(r == 8'h12, "R2 mode 00 data kept", r, 8'h12);
        wr(1'b1, 8'hFF);
        watch_tx_quiet(1000, quiet);
        check(quiet, "R2 mode 00 sends nothing", quiet, 1);
        rd(1'b0, r);
        check(r[2] == 1'b0, "R2 mode 00 no tx done", r[2], 0);
    endtask

    task automatic t_glitch();
        logic [7:0] r;
        wr(1'b0, MODE8 | RXEN);
        @(negedge clk);
        rx_line = 1'b0;
        idle(16);                   // a quarter bit
        rx_line = 1'b1;
        idle(800);
        rd(1'b0, r);
        check(r[3] == 1'b0, "R9 short start rejected", r[3], 0);
        drive_frame(8'h99, 1'b0, 1'b0);
        idle(8);
        rd(1'b0, r);
        check(r[3] == 1'b1, "R9 frame after glitch done", r[3], 1);
        rd(1'b1, r);
        check(r == 8'h99, "R9 frame after glitch data", r, 8'h99);
        wr(1'b0, MODE8 | RXEN);
    endtask

    task automatic t_race();
        logic [7:0] r;
        bit seen = 1'b0;
        fork
            drive_frame(8'h0F, 1'b0, 1'b0);
            begin
                @(negedge clk);
                bus_addr  = 1'b0;
                bus_wdata = MODE8 | RXEN; // clears rx done every cycle
                bus_wr    = 1'b1;
                repeat (11 * BIT_CLK + 20) begin
                    @(negedge clk);
                    #1;
                    if (bus_rdata[3]) seen = 1'b1;
                end
                @(negedge clk);
                bus_wr = 1'b0;
            end
        join
        check(seen, "R10 set wins over clear", seen, 1);
        rd(1'b0, r);
        check(r[3] == 1'b0, "R10 later clear takes effect", r[3], 0);
        rd(1'b1, r);
        check(r == 8'h0F, "R5 data under write storm", r, 8'h0F);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_tx_byte();
        t_tx_nine();
        t_rx_byte();
        t_rx_nine();
        t_mp_filter();
        t_rx_off();
        t_glitch();
        t_race();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule